// File: doc/BRIEF.md
# Tagged Circular Register Stack

This block holds eight 80-bit extended-precision values in a ring of physical slots. The slots are addressed relative to a 3-bit top pointer, and a 16-bit tag word marks each slot as holding a value or as empty. A single 4-bit command selects one operation per clock: push, pop, read, write, free, pointer increment, pointer decrement or initialize. Relative addressing wraps, so relative slot i lives in physical slot (i + top) mod 8.

Stack faults are found from the tags alone. A push onto a slot that still holds a value is an overflow. A pop or read of an empty slot is an underflow. Each fault sets its own pattern of sticky status bits. An underflowing access returns a negative quiet NaN in place of the stored word. Arithmetic, number-format conversion and instruction decode sit outside the block. It is used as the register file behind a stack-oriented floating-point datapath.

Top module: `fstk_regstack`

## Requirements
- R1: Reset (synchronous, active high) and the init command leave tag_word = 16'hFFFF and status_word = 16'h0000 (top = 0, all flags clear) from the next cycle on.
- R2: Relative slot i maps to physical slot (i + top) mod 8. Physical slot k owns tag_word bits [2k+1:2k], where 2'b00 means valid and 2'b11 means empty. status_word bits [13:11] hold top.
- R3: A push decrements top by one, writes din into the new relative slot 0 and tags that slot valid. All of this is visible one cycle after the command.
- R4: If physical slot (top - 1) is not empty when a push is issued, the push sets the invalid bit (status bit 0), the stack-fault bit (bit 6) and the direction bit (bit 9). The push still completes as in R3.
- R5: A pop of a non-empty relative slot 0 drives dout with that slot's value during the command cycle. It then tags the slot empty and increments top.
- R6: A pop of an empty relative slot 0 drives dout = 80'hFFFF_C000_0000_0000_0000, sets the invalid and stack-fault bits, clears the direction bit and still increments top.
- R7: For every command except pop, dout shows relative slot sel, or the NaN of R6 if that slot is empty. A read command on an empty slot raises the same flags as R6 and leaves top unchanged.
- R8: A write command stores din into relative slot sel, tags it valid and leaves top unchanged.
- R9: A free command tags relative slot sel empty and changes neither top nor any other tag.
- R10: The increment and decrement commands change top by +1 and -1 modulo 8 (0 - 1 = 7) and leave the tag word untouched.
- R11: Once set, the invalid and stack-fault bits stay set until reset or init.
- R12: The command codes are 0 nop, 1 push, 2 pop, 3 read, 4 write, 5 free, 6 increment, 7 decrement, 8 init. Codes 9 to 15 act as nop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, same effect as init |
| cmd | input | 4 | Command code for this cycle |
| sel | input | 3 | Relative slot index for read, write and free |
| din | input | 80 | Data for push and write |
| dout | output | 80 | Popped or read value, NaN-substituted when empty |
| tag_word | output | 16 | Two-bit tag per physical slot |
| status_word | output | 16 | Flags and top pointer |

## Verification
The hardest condition to reach is an overflow. It needs all eight slots valid with the pointer wrapped fully round, so that the slot just above the top is still occupied. The bench gets there with eight pushes after init and a ninth push. It then checks that the ninth value replaced the oldest one while the eighth stays at relative slot 1. From that full state it frees slot 0 and reads it, to show an underflow clearing the direction bit that the overflow set. It then pops after moving the pointer, to show the invalid and fault bits stay set.

// File: rtl/fstk_pkg.sv
package fstk_pkg;
    localparam int unsigned SLOTS    = 8;
    localparam int unsigned DW       = 80;
    localparam int unsigned PW       = $clog2(SLOTS);
    localparam int unsigned TW       = 2 * SLOTS;
    localparam int unsigned SWW      = 16;
    localparam int unsigned TOP_LSB  = 11;
    localparam int unsigned INV_BIT  = 0;
    localparam int unsigned SFLT_BIT = 6;
    localparam int unsigned DIR_BIT  = 9;

    typedef logic [PW-1:0] ptr_t;
    typedef logic [DW-1:0] word_t;
    typedef logic [TW-1:0] tagw_t;
    typedef logic [1:0]    tag_t;

    localparam tag_t  TAG_VALID = 2'b00;
    localparam tag_t  TAG_EMPTY = 2'b11;
    localparam word_t NEG_QNAN  = word_t'({1'b1, 15'h7FFF, 2'b11, 62'h0});

    typedef enum logic [3:0] {
        CMD_NOP   = 4'd0,
        CMD_PUSH  = 4'd1,
        CMD_POP   = 4'd2,
        CMD_READ  = 4'd3,
        CMD_WRITE = 4'd4,
        CMD_FREE  = 4'd5,
        CMD_INC   = 4'd6,
        CMD_DEC   = 4'd7,
        CMD_INIT  = 4'd8
    } cmd_e;

    typedef struct packed {
        logic inv;
        logic sflt;
        logic dirn;
        ptr_t top;
    } stat_t;

    function automatic tag_t get_tag(tagw_t w, ptr_t s);
        return w[2*s +: 2];
    endfunction

    function automatic tagw_t put_tag(tagw_t w, ptr_t s, tag_t t);
        tagw_t r;
        r = w;
        for (int k = 0; k < SLOTS; k++) begin
            if (ptr_t'(k) == s) r[2*k +: 2] = t;
        end
        return r;
    endfunction

    function automatic logic [SWW-1:0] pack_status(stat_t s);
        logic [SWW-1:0] w;
        w = '0;
        w[INV_BIT]         = s.inv;
        w[SFLT_BIT]        = s.sflt;
        w[DIR_BIT]         = s.dirn;
        w[TOP_LSB +: PW]   = s.top;
        return w;
    endfunction
endpackage

// File: rtl/fstk_regfile.sv
module fstk_regfile
    import fstk_pkg::*;
(
    input  logic  clk,
    input  logic  we,
    input  ptr_t  waddr,
    input  word_t wdata,
    input  ptr_t  raddr,
    output word_t rdata
);
    word_t slot_q [SLOTS];

    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
        always_ff @(posedge clk) begin
            if (we && waddr == ptr_t'(k)) slot_q[k] <= wdata;
        end
    end

    assign rdata = slot_q[raddr];
endmodule

// File: rtl/fstk_tagctl.sv
module fstk_tagctl
    import fstk_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  cmd_e  cmd,
    input  ptr_t  sel,
    output tagw_t tags,
    output stat_t stat,
    output logic  we,
    output ptr_t  waddr,
    output ptr_t  raddr,
    output logic  rd_empty
);
    tagw_t tags_q, tags_d;
    stat_t st_q, st_d;

    ptr_t push_slot, sel_slot;
    logic push_full;

    assign push_slot = st_q.top - 1'b1;
    assign sel_slot  = st_q.top + sel;
    assign raddr     = (cmd == CMD_POP) ? st_q.top : sel_slot;
    assign rd_empty  = get_tag(tags_q, raddr) == TAG_EMPTY;
    assign push_full = get_tag(tags_q, push_slot) != TAG_EMPTY;
    assign we        = (cmd == CMD_PUSH) || (cmd == CMD_WRITE);
    assign waddr     = (cmd == CMD_PUSH) ? push_slot : sel_slot;

    always_comb begin
        tags_d = tags_q;
        st_d   = st_q;
        case (cmd)
            CMD_PUSH: begin
                if (push_full) begin
                    st_d.inv  = 1'b1;
                    st_d.sflt = 1'b1;
                    st_d.dirn = 1'b1;
                end
                st_d.top = push_slot;
                tags_d   = put_tag(tags_q, push_slot, TAG_VALID);
            end
            CMD_POP: begin
                if (rd_empty) begin
                    st_d.inv  = 1'b1;
                    st_d.sflt = 1'b1;
                    st_d.dirn = 1'b0;
                end else begin
                    tags_d = put_tag(tags_q, st_q.top, TAG_EMPTY);
                end
                st_d.top = st_q.top + 1'b1;
            end
            CMD_READ: begin
                if (rd_empty) begin
                    st_d.inv  = 1'b1;
                    st_d.sflt = 1'b1;
                    st_d.dirn = 1'b0;
                end
            end
            CMD_WRITE: tags_d = put_tag(tags_q, sel_slot, TAG_VALID);
            CMD_FREE:  tags_d = put_tag(tags_q, sel_slot, TAG_EMPTY);
            CMD_INC:   st_d.top = st_q.top + 1'b1;
            CMD_DEC:   st_d.top = st_q.top - 1'b1;
            CMD_INIT: begin
                tags_d = '1;
                st_d   = '0;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tags_q <= '1;
            st_q   <= '0;
        end else begin
            tags_q <= tags_d;
            st_q   <= st_d;
        end
    end

    assign tags = tags_q;
    assign stat = st_q;

    a_r1_init_clears: assert property (@(posedge clk) disable iff (rst)
        cmd == CMD_INIT |=> (tags_q == '1 && st_q == '0));
    a_r3_push_moves_top: assert property (@(posedge clk) disable iff (rst)
        cmd == CMD_PUSH |=> st_q.top == ptr_t'($past(st_q.top) - 1'b1));
    a_r4_overflow_flags: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_PUSH && push_full) |=> (st_q.inv && st_q.sflt && st_q.dirn));
    a_r6_underflow_flags: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_POP && rd_empty) |=> (st_q.inv && st_q.sflt && !st_q.dirn));
    a_r9_free_keeps_top: assert property (@(posedge clk) disable iff (rst)
        cmd == CMD_FREE |=> st_q.top == $past(st_q.top));
    a_r10_inc_keeps_tags: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_INC || cmd == CMD_DEC) |=> $stable(tags_q));
    a_r11_sticky_flags: assert property (@(posedge clk) disable iff (rst)
        (st_q.inv && st_q.sflt && cmd != CMD_INIT) |=> (st_q.inv && st_q.sflt));
endmodule

// File: rtl/fstk_regstack.sv
module fstk_regstack
    import fstk_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [3:0]      cmd,
    input  logic [PW-1:0]   sel,
    input  logic [DW-1:0]   din,
    output logic [DW-1:0]   dout,
    output logic [TW-1:0]   tag_word,
    output logic [SWW-1:0]  status_word
);
    cmd_e  cmd_c;
    tagw_t tags;
    stat_t stat;
    logic  we, rd_empty;
    ptr_t  waddr, raddr;
    word_t rdata;

    assign cmd_c = cmd_e'(cmd);

    fstk_tagctl u_tagctl (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd_c),
        .sel      (sel),
        .tags     (tags),
        .stat     (stat),
        .we       (we),
        .waddr    (waddr),
        .raddr    (raddr),
        .rd_empty (rd_empty)
    );

    fstk_regfile u_regfile (
        .clk   (clk),
        .we    (we),
        .waddr (waddr),
        .wdata (din),
        .raddr (raddr),
        .rdata (rdata)
    );

    assign dout        = rd_empty ? NEG_QNAN : rdata;
    assign tag_word    = tags;
    assign status_word = pack_status(stat);

    a_r5_pop_frees_slot: assert property (@(posedge clk) disable iff (rst)
        (cmd_c == CMD_POP && !rd_empty) |=> tag_word[2*$past(raddr) +: 2] == TAG_EMPTY);
endmodule

// File: tb/fstk_regstack_bench.sv
module fstk_regstack_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  cmd = 4'd0;
    logic [2:0]  sel = 3'd0;
    logic [79:0] din = '0;
    logic [79:0] dout;
    logic [15:0] tag_word, status_word;
    logic [79:0] last_dout;
    int checks = 0;
    int fails  = 0;

    localparam logic [79:0] NAN = 80'hFFFF_C000_0000_0000_0000;

    fstk_regstack u_fstk_regstack (
        .clk(clk), .rst(rst), .cmd(cmd), .sel(sel), .din(din),
        .dout(dout), .tag_word(tag_word), .status_word(status_word)
    );

    always #10 clk = ~clk;

    function automatic logic [79:0] val(int k);
        return {16'h4000 + 16'(k), 64'h8000_0000_0000_0000 | 64'(k * 7)};
    endfunction

    task automatic chk16(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk80(string req, logic [79:0] act, logic [79:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(logic [3:0] c, logic [2:0] s, logic [79:0] d);
        @(negedge clk);
        cmd = c; sel = s; din = d;
        #2 last_dout = dout;
        @(posedge clk);
        #1 cmd = 4'd0;
    endtask

    task automatic state(string req, logic [15:0] t, logic [15:0] s);
        chk16({req, " tag"}, tag_word, t);
        chk16({req, " status"}, status_word, s);
    endtask

    task automatic t_reset;
        state("R1 reset", 16'hFFFF, 16'h0000);
    endtask

    task automatic t_push_pop_basic;
        step(4'd1, 3'd0, val(1));
        step(4'd1, 3'd0, val(2));
        step(4'd1, 3'd0, val(3));
        state("R3 three pushes", 16'h03FF, 16'h2800);
        step(4'd3, 3'd0, '0);
        chk80("R3 newest at slot 0", last_dout, val(3));
        step(4'd3, 3'd2, '0);
        chk80("R2 oldest at slot 2", last_dout, val(1));
        step(4'd2, 3'd0, '0);
        chk80("R5 pop value", last_dout, val(3));
        state("R5 after pop", 16'h0FFF, 16'h3000);
    endtask

    task automatic t_write_free_read;
        step(4'd4, 3'd3, val(9));
        state("R8 write slot 3", 16'h0FF3, 16'h3000);
        step(4'd3, 3'd3, '0);
        chk80("R8 read back", last_dout, val(9));
        step(4'd5, 3'd1, '0);
        state("R9 free slot 1", 16'hCFF3, 16'h3000);
        step(4'd3, 3'd0, '0);
        chk80("R9 neighbour kept", last_dout, val(2));
        step(4'd3, 3'd1, '0);
        chk80("R7 empty read NaN", last_dout, NAN);
        state("R7 read underflow", 16'hCFF3, 16'h3041);
    endtask

    task automatic t_overflow_sticky;
        step(4'd8, 3'd0, '0);
        state("R1 init cmd", 16'hFFFF, 16'h0000);
        for (int k = 1; k <= 8; k++) step(4'd1, 3'd0, val(10 + k));
        state("R3 full", 16'h0000, 16'h0000);
        step(4'd1, 3'd0, val(30));
        state("R4 overflow", 16'h0000, 16'h3A41);
        step(4'd3, 3'd0, '0);
        chk80("R4 push completed", last_dout, val(30));
        step(4'd3, 3'd1, '0);
        chk80("R4 prior top kept", last_dout, val(18));
        step(4'd5, 3'd0, '0);
        step(4'd3, 3'd0, '0);
        chk80("R7 freed read NaN", last_dout, NAN);
        state("R7 underflow clears dir", 16'hC000, 16'h3841);
        step(4'd6, 3'd0, '0);
        state("R10 inc keeps tags", 16'hC000, 16'h0041);
        step(4'd2, 3'd0, '0);
        chk80("R5 pop after inc", last_dout, val(18));
        state("R11 flags sticky", 16'hC003, 16'h0841);
    endtask

    task automatic t_underflow_pop;
        step(4'd8, 3'd0, '0);
        step(4'd2, 3'd0, '0);
        chk80("R6 pop NaN", last_dout, NAN);
        state("R6 pop underflow", 16'hFFFF, 16'h0841);
    endtask

    task automatic t_wrap_and_nop;
        step(4'd8, 3'd0, '0);
        step(4'd7, 3'd0, '0);
        state("R10 dec wraps", 16'hFFFF, 16'h3800);
        step(4'd6, 3'd0, '0);
        step(4'd6, 3'd0, '0);
        state("R10 inc twice", 16'hFFFF, 16'h0800);
        step(4'd15, 3'd2, val(5));
        state("R12 unused code", 16'hFFFF, 16'h0800);
        step(4'd3, 3'd2, '0);
        chk80("R12 unused wrote nothing", last_dout, NAN);
    endtask

    task automatic t_reset_mid;
        step(4'd1, 3'd0, val(4));
        @(negedge clk) rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        state("R1 reset mid run", 16'hFFFF, 16'h0000);
    endtask

    initial begin
        #(20 * 100000);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_push_pop_basic();
        t_write_free_read();
        t_overflow_sticky();
        t_underflow_pop();
        t_wrap_and_nop();
        t_reset_mid();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule